// File: doc/BRIEF.md
# Reset-Sampled Breakpoint Mode Gate

This block decides, once per reset, whether breakpoints put the processor into background debug mode or raise an ordinary breakpoint exception. It watches an active-low, asynchronous breakpoint pin through a synchronizer. At the first clock edge after reset is released, it looks at the synchronized pin level. If the pin has been low for the required hold window, debug mode is enabled; otherwise it is disabled. That choice is held until reset is asserted again.

Once the choice is made, every breakpoint request is steered to one of two one-cycle outputs. A request is either a fresh falling edge of the synchronized pin or a pulse on the internal breakpoint input. With debug mode on, the request goes to the debug-entry strobe; with it off, it goes to the exception-request strobe.

The reset input is asserted asynchronously. Its release is expected to be synchronous to the clock already. The first rising clock edge with reset high is the capture edge.

Top module: `brk_mode_gate`

## Requirements
- R1: The pin passes through a two-flop synchronizer. A falling edge of the pin that is first sampled at rising clock edge N produces its strobe in the cycle after edge N+2, lasting exactly one cycle.
- R2: At the capture edge, debug mode is enabled when the pin was sampled low at the second and third rising edges before the capture edge. `dbg_enabled` reads 1 from the capture edge onward.
- R3: If the pin is high across that window, `dbg_enabled` reads 0 after the capture edge.
- R4: A low level sampled at only one of the two window edges leaves debug mode disabled.
- R5: After the capture edge, `dbg_enabled` keeps its value until the next reset, whatever the pin and internal input do.
- R6: Every release of reset performs a new capture, so successive resets can select different modes.
- R7: With debug mode enabled, a request pulses `dbg_enter` and leaves `brk_exc` low.
- R8: With debug mode disabled, a request pulses `brk_exc` and leaves `dbg_enter` low.
- R9: A high cycle on `brk_int` sampled at edge N produces the routed strobe in the cycle after edge N.
- R10: A pin that is still low across reset release is not a request. The synchronized level must be seen high at or after the capture edge before a falling edge counts.
- R11: The strobes are never high together. A pin held low yields a single strobe. While reset is asserted, both strobes and `dbg_enabled` are 0, and `brk_int` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| brk_pin_n | input | 1 | Asynchronous active-low breakpoint pin |
| brk_int | input | 1 | Internal breakpoint pulse, synchronous to clk |
| dbg_enabled | output | 1 | Captured debug-mode enable |
| dbg_enter | output | 1 | One-cycle debug-entry strobe |
| brk_exc | output | 1 | One-cycle breakpoint exception request |

## Verification
Each result has a fixed due time:
- A pin fall driven before edge N is due after edge N+2.
- An internal pulse driven before edge N is due after edge N.
- The enable flag is due after the first edge following reset release.

The driver computes each due cycle from the cycle count at the moment it drives the stimulus and queues it. The monitor compares both strobes at every falling clock edge, so any strobe arriving early, late, or twice shows up as a mismatch in that exact cycle. Reset windows are built from explicit per-cycle pin patterns, so the hold-window boundary and the one-sample-short cases are reached deterministically.

// File: rtl/brk_gate_pkg.sv
package brk_gate_pkg;

  typedef struct packed {
    logic enter;
    logic exc;
  } brk_strobe_t;

endpackage

// File: rtl/brk_pin_sync.sv
module brk_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic lvl,
  output logic held_low
);
  localparam int unsigned CHAIN = SYNC_STAGES + HOLD_CYC - 1;

  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_d;

  // shift chain: the first SYNC_STAGES flops synchronize, the rest keep history
  for (genvar g = 0; g < CHAIN; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign chain_d[g] = pin_n;
    end else begin : g_tail
      assign chain_d[g] = chain_q[g-1];
    end
  end

  // no reset: the pin must still be observed while reset is asserted
  always_ff @(posedge clk) begin
    chain_q <= chain_d;
  end

  assign lvl      = chain_q[SYNC_STAGES-1];
  assign held_low = ~|chain_q[CHAIN-1:SYNC_STAGES-1];

endmodule

// File: rtl/brk_mode_capture.sv
module brk_mode_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic held_low,
  output logic armed,
  output logic dbg_en
);
  logic armed_q, armed_d;
  logic en_q, en_d;
  logic load;

  always_comb begin
    load    = ~armed_q;
    armed_d = 1'b1;
    en_d    = held_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (load) begin
      armed_q <= armed_d;
      en_q    <= en_d;
    end
  end

  assign armed  = armed_q;
  assign dbg_en = en_q;

  // R2/R3/R4: the flag follows the filtered pin window seen at the capture edge
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> (en_q == $past(held_low)));

  // R5: once armed the mode never moves
  assert_mode_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(armed_q) |-> $stable(en_q));

endmodule

// File: rtl/brk_req_route.sv
module brk_req_route
  import brk_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic        dbg_en,
  input  logic        lvl,
  input  logic        int_pulse,
  output brk_strobe_t strobe
);
  logic        prev_q, prev_d;
  logic        fall;
  logic        req;
  brk_strobe_t strb_q, strb_d;

  always_comb begin
    prev_d       = lvl;
    fall         = prev_q & ~lvl;
    req          = armed & (fall | int_pulse);
    strb_d.enter = req & dbg_en;
    strb_d.exc   = req & ~dbg_en;
  end

  // prev resets low so a pin held low across release is never a fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      strb_q <= '0;
    end else begin
      prev_q <= prev_d;
      strb_q <= strb_d;
    end
  end

  assign strobe = strb_q;

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb_q.enter && strb_q.exc));

  assert_enter_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.enter |-> $past(dbg_en));

  assert_exc_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q.exc |-> !$past(dbg_en));

  assert_armed_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_q.enter || strb_q.exc) |-> $past(armed));

endmodule

// File: rtl/brk_mode_gate.sv
module brk_mode_gate
  import brk_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_pin_n,
  input  logic brk_int,
  output logic dbg_enabled,
  output logic dbg_enter,
  output logic brk_exc
);
  logic        lvl;
  logic        held_low;
  logic        armed;
  logic        dbg_en;
  brk_strobe_t strobe;

  brk_pin_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .HOLD_CYC    (HOLD_CYC)
  ) u_sync (
    .clk      (clk),
    .pin_n    (brk_pin_n),
    .lvl      (lvl),
    .held_low (held_low)
  );

  brk_mode_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .held_low (held_low),
    .armed    (armed),
    .dbg_en   (dbg_en)
  );

  brk_req_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .dbg_en    (dbg_en),
    .lvl       (lvl),
    .int_pulse (brk_int),
    .strobe    (strobe)
  );

  assign dbg_enabled = dbg_en;
  assign dbg_enter   = strobe.enter;
  assign brk_exc     = strobe.exc;

endmodule

// File: tb/brk_mode_gate_test.sv
module brk_mode_gate_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, brk_pin_n, brk_int;
  logic dbg_enabled, dbg_enter, brk_exc;

  brk_mode_gate uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .brk_pin_n   (brk_pin_n),
    .brk_int     (brk_int),
    .dbg_enabled (dbg_enabled),
    .dbg_enter   (dbg_enter),
    .brk_exc     (brk_exc)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int    due;
    bit    ent;
    bit    exc;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(int due, bit ent, bit exc, string tag);
    exp_t e;
    e.due = due; e.ent = ent; e.exc = exc; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: every cycle, strobes must match the queued item due now, else be low
  bit    mon_on = 1'b0;
  bit    m_ent, m_exc;
  string m_tag;
  always @(negedge clk) begin
    if (mon_on) begin
      m_ent = 1'b0; m_exc = 1'b0; m_tag = "R11";
      if (sb.size() > 0 && sb[0].due == cyc) begin
        m_ent = sb[0].ent; m_exc = sb[0].exc; m_tag = sb[0].tag;
        void'(sb.pop_front());
      end
      check(m_tag, dbg_enter, m_ent, "debug-entry strobe");
      check(m_tag, brk_exc, m_exc, "exception strobe");
    end
  end

  // pin falls before edge cyc+1; strobe due after edge cyc+3 (R1), held low 5 cycles (R11)
  task automatic pin_fall(bit en, string tag);
    @(negedge clk);
    brk_pin_n = 1'b0;
    push(cyc + 3, en, !en, tag);
    repeat (5) @(negedge clk);
    brk_pin_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic int_pulse(bit en, string tag);
    @(negedge clk);
    brk_int = 1'b1;
    push(cyc + 1, en, !en, tag);
    @(negedge clk);
    brk_int = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // pat[3] driven first; window = pat[2], pat[1]
  task automatic do_reset(logic [3:0] pat, logic post, bit exp_en, string tag);
    @(negedge clk);
    rst_n = 1'b0;
    brk_pin_n = 1'b1;
    @(negedge clk);
    brk_int = 1'b1;           // R11: ignored while in reset
    @(negedge clk);
    brk_int = 1'b0;
    @(negedge clk);
    check("R11", dbg_enabled, 1'b0, "enable flag in reset");
    for (int i = 3; i >= 0; i--) begin
      @(negedge clk);
      brk_pin_n = pat[i];
    end
    @(negedge clk);
    rst_n = 1'b1;
    brk_pin_n = post;
    @(negedge clk);
    check(tag, dbg_enabled, exp_en, "enable flag after release");
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    brk_pin_n = 1'b1;
    brk_int = 1'b0;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    check("R11", dbg_enabled, 1'b0, "enable flag at reset");

    // R2 with pin held low across release: no request (R10)
    do_reset(4'b0000, 1'b0, 1'b1, "R2");
    repeat (4) @(negedge clk);
    check("R5", dbg_enabled, 1'b1, "enable held while pin low");
    brk_pin_n = 1'b1;
    repeat (4) @(negedge clk);
    pin_fall(1'b1, "R7");
    int_pulse(1'b1, "R9");
    check("R5", dbg_enabled, 1'b1, "enable held after requests");

    // R3 / R6: new capture with pin high
    do_reset(4'b1111, 1'b1, 1'b0, "R3");
    pin_fall(1'b0, "R8");
    int_pulse(1'b0, "R9");
    check("R5", dbg_enabled, 1'b0, "disable held after requests");

    // R6 / R2: exact two-sample window
    do_reset(4'b1001, 1'b1, 1'b1, "R6");
    pin_fall(1'b1, "R1");

    // R4: only one window sample low
    do_reset(4'b1011, 1'b1, 1'b0, "R4");
    do_reset(4'b1101, 1'b1, 1'b0, "R4");
    int_pulse(1'b0, "R8");

    repeat (4) @(negedge clk);
    check("R1", sb.size() == 0, 1'b1, "all expected strobes seen");
    mon_on = 1'b0;
    report();
    $finish;
  end

endmodule